// File: doc/BRIEF.md
# Register-Driven Serial Peripheral Master

This block is a serial peripheral master with a single device select, controlled through a small 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe with combinational read data. Software first sets a clock divider and a word width of 8 or 16 bits. It then asserts the device select through a control bit and writes a transmit word, which starts one full-duplex exchange.

The serial clock idles low. The master presents output data while the clock is low, samples the input line on each rising clock edge, and moves to the next output bit on each falling edge. Bits go out most significant first. When the last falling edge of a word has passed, a completion flag is set and the received word is held for reading. The same flag drives a level interrupt output, and software clears it by writing zero. The divider is programmed with a 5-bit code, so the serial clock can be any even fraction of the system clock from 1/4 to 1/30.

Top module: `spim_regbus`

## Requirements
- R1: After reset, `sel_n` is 1, `sclk` is 0, `irq` is 0, and the registers at 0x00, 0x04, 0x0C and 0x10 all read 0.
- R2: Bit 0 of the control register at 0x00 drives the device select. Writing 1 makes `sel_n` go low from the next clock, and writing 0 makes it go high. The bit reads back.
- R3: The configuration register at 0x04 keeps bits [4:0] (divider code), bit 5 (1 selects 16-bit words) and bit 14 (a timing-adjust bit that is only stored). All of these read back. Every other bit reads 0.
- R4: A divider code of 0x10+k, with k from 2 to 15, gives a serial clock period of 2k system clocks, with k clocks low and k clocks high.
- R5: A divider code with bit 4 clear, or 0x10+k with k below 2, divides by 4.
- R6: `sclk` is low whenever no exchange is running. During a word, `mosi` changes only on a falling `sclk` edge. `miso` is sampled at each rising edge.
- R7: In 8-bit mode, a write to the transmit register at 0x08 sends bits [7:0], most significant first, over exactly 8 clock pulses. The receive register at 0x0C then holds the 8 sampled bits in [7:0], with [31:8] reading 0.
- R8: In 16-bit mode, the exchange sends bits [15:0], most significant first, over exactly 16 pulses. The receive register holds all 16 sampled bits.
- R9: Bit 0 of the cause register at 0x10 and the `irq` output become 1 exactly W·N system clocks after the transmit write is accepted, where W is the word size and N the divide ratio. Writing a value with bit 0 clear resets them to 0. Writing 1 does not set them.
- R10: A transmit write that arrives while a word is in progress is ignored. The current word keeps its data, its pulse count and its completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe, 0 otherwise |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 1 | Device select, active low |
| irq | output | 1 | Level interrupt, equal to the completion flag |

## Verification
Several properties are checked on every cycle by the assertions. The serial clock stays low while the engine is idle. The output bit never moves except on a falling serial clock edge. Divider ticks never fall on adjacent cycles. The device select follows each control write. The completion flag rises after the last falling edge and drops after a clearing write. A transmit write during a word leaves the engine busy with its latched width. Some behaviours can only be shown by the bench's directed exchanges with a modelled slave: the actual bit order and pulse count, the received value, the exact exchange length in system clocks for each divider code, and the divide-by-4 fallback for codes outside the valid range.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned SPIM_AW = 5;
  localparam int unsigned SPIM_DW = 32;

  localparam logic [SPIM_AW-1:0] OFS_CTRL  = 5'h00;
  localparam logic [SPIM_AW-1:0] OFS_CFG   = 5'h04;
  localparam logic [SPIM_AW-1:0] OFS_TX    = 5'h08;
  localparam logic [SPIM_AW-1:0] OFS_RX    = 5'h0C;
  localparam logic [SPIM_AW-1:0] OFS_CAUSE = 5'h10;

  localparam int unsigned CFG_W16_BIT  = 5;
  localparam int unsigned CFG_TADJ_BIT = 14;

  // Half period, in system clocks, selected by a divider code.
  // Valid codes are 0x10 + k with k >= 2. Anything else gives a half period of 2.
  function automatic logic [3:0] spim_half(input logic [4:0] code);
    if (!code[4] || (code[3:0] < 4'd2)) return 4'd2;
    return code[3:0];
  endfunction

  // Number of bits in a word for the selected width.
  function automatic logic [4:0] spim_bits(input logic w16);
    return w16 ? 5'd16 : 5'd8;
  endfunction
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int unsigned AW = SPIM_AW,
  parameter int unsigned DW = SPIM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  input  logic          done_evt,
  input  logic [15:0]   rx_word,
  output logic          cs_en,
  output logic [4:0]    cfg_code,
  output logic          cfg_w16,
  output logic          tx_wr,
  output logic [15:0]   tx_word,
  output logic          cause
);
  logic cfg_tadj;
  logic wr_ctrl, wr_cfg, wr_cause;

  assign wr_ctrl  = wr && (addr == OFS_CTRL);
  assign wr_cfg   = wr && (addr == OFS_CFG);
  assign wr_cause = wr && (addr == OFS_CAUSE);
  assign tx_wr    = wr && (addr == OFS_TX);
  assign tx_word  = wdata[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en    <= 1'b0;
      cfg_code <= '0;
      cfg_w16  <= 1'b0;
      cfg_tadj <= 1'b0;
      cause    <= 1'b0;
    end else begin
      if (wr_ctrl) cs_en <= wdata[0];
      if (wr_cfg) begin
        cfg_code <= wdata[4:0];
        cfg_w16  <= wdata[CFG_W16_BIT];
        cfg_tadj <= wdata[CFG_TADJ_BIT];
      end
      if (done_evt)                   cause <= 1'b1;
      else if (wr_cause && !wdata[0]) cause <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        OFS_CTRL:  rdata[0] = cs_en;
        OFS_CFG: begin
          rdata[4:0]          = cfg_code;
          rdata[CFG_W16_BIT]  = cfg_w16;
          rdata[CFG_TADJ_BIT] = cfg_tadj;
        end
        OFS_RX:    rdata[15:0] = rx_word;
        OFS_CAUSE: rdata[0] = cause;
        default:   rdata = '0;
      endcase
    end
  end

  // R2: the select enable follows the last control write
  p_cs_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (cs_en == $past(wdata[0])));
  // R9: completion sets the flag
  p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> cause);
  // R9: a clearing write without completion drops the flag
  p_cause_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && !wdata[0] && !done_evt) |=> !cause);
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [4:0] code,
  input  logic       run,
  output logic       tick
);
  logic [3:0] half_q;
  logic [3:0] cnt;

  assign tick = run && !load && (cnt == half_q - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 4'd2;
      cnt    <= '0;
    end else if (load) begin
      half_q <= spim_half(code);
      cnt    <= '0;
    end else if (run) begin
      cnt <= tick ? 4'd0 : cnt + 4'd1;
    end
  end

  // R5: the latched half period always lies in the legal range
  p_half_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (half_q >= 4'd2));
  // R4: two half-period ticks are never adjacent
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_wr,
  input  logic        w16,
  input  logic [15:0] tx_word,
  input  logic        miso,
  input  logic        tick,
  output logic        accept,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  output logic        done_evt,
  output logic [15:0] rx_word
);
  logic [15:0] tx_sh, rx_sh;
  logic [3:0]  bit_idx;
  logic        w16_q;
  logic        last_bit;

  assign accept   = tx_wr && !busy;
  assign last_bit = (bit_idx == (w16_q ? 4'd15 : 4'd7));
  assign done_evt = busy && tick && sclk && last_bit;
  assign mosi     = tx_sh[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_idx <= '0;
      w16_q   <= 1'b0;
      rx_word <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      sclk    <= 1'b0;
      bit_idx <= '0;
      w16_q   <= w16;
      tx_sh   <= w16 ? tx_word : {tx_word[7:0], 8'h00};
    end else if (busy && tick) begin
      if (!sclk) begin
        sclk  <= 1'b1;
        rx_sh <= {rx_sh[14:0], miso};
      end else begin
        sclk <= 1'b0;
        if (last_bit) begin
          busy    <= 1'b0;
          rx_word <= w16_q ? rx_sh : {8'h00, rx_sh[7:0]};
        end else begin
          bit_idx <= bit_idx + 4'd1;
          tx_sh   <= {tx_sh[14:0], 1'b0};
        end
      end
    end
  end

  // R6: the serial clock idles low
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R6: within a word the output bit moves only on a falling clock edge
  p_mosi_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mosi)) |-> $fell(sclk));
  // R10: a transmit write during a word neither ends nor re-arms it
  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && busy && !done_evt) |=> (busy && $stable(w16_q)));
endmodule

// File: rtl/spim_regbus.sv
module spim_regbus
  import spim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        sel_n,
  output logic        irq
);
  logic        cs_en, cfg_w16, tx_wr, cause;
  logic        accept, busy, tick, done_evt;
  logic [4:0]  cfg_code;
  logic [15:0] tx_word, rx_word;

  spim_regs #(.AW(SPIM_AW), .DW(SPIM_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata), .done_evt(done_evt), .rx_word(rx_word),
    .cs_en(cs_en), .cfg_code(cfg_code), .cfg_w16(cfg_w16), .tx_wr(tx_wr),
    .tx_word(tx_word), .cause(cause)
  );

  spim_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .code(cfg_code), .run(busy), .tick(tick)
  );

  spim_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .w16(cfg_w16), .tx_word(tx_word),
    .miso(miso), .tick(tick), .accept(accept), .busy(busy), .sclk(sclk),
    .mosi(mosi), .done_evt(done_evt), .rx_word(rx_word)
  );

  assign sel_n = ~cs_en;
  assign irq   = cause;

  // R9: the interrupt output only rises at a word's completion
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_evt));
endmodule

// File: tb/spim_regbus_tb.sv
`timescale 1ns/1ps
module spim_regbus_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, sel_n, irq;
  logic        miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  spim_regbus dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .sel_n(sel_n), .irq(irq)
  );

  // Slave model and capture
  logic [15:0] slv_word;
  int          slv_idx;
  logic [15:0] cap;
  int          pulses;
  time         t_rise0, t_rise1;
  logic        mosi_at_rise;
  int          mosi_bad;

  always @(negedge sclk) begin
    if (slv_idx > 0) slv_idx = slv_idx - 1;
    miso = slv_word[slv_idx];
  end

  always @(posedge sclk) begin
    cap = {cap[14:0], mosi};
    mosi_at_rise = mosi;
    if (pulses == 0) t_rise0 = $time;
    if (pulses == 1) t_rise1 = $time;
    pulses = pulses + 1;
  end

  always @(negedge clk) begin
    if (sclk && (mosi !== mosi_at_rise)) mosi_bad = mosi_bad + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // One exchange. mid_at > 0 issues a second transmit write mid-word.
  task automatic run_word(input string tag, input logic [4:0] code, input logic w16,
                          input logic [31:0] txv, input logic [15:0] slv,
                          input int n_exp, input int mid_at);
    int          w = w16 ? 16 : 8;
    int          cnt = 0;
    logic [31:0] rd;
    logic [15:0] exp_tx = w16 ? txv[15:0] : {8'h00, txv[7:0]};
    logic [31:0] exp_rx = w16 ? {16'h0, slv} : {24'h0, slv[7:0]};
    bus_write(5'h04, {26'h0, w16, code});
    bus_write(5'h00, 32'h1);
    bus_write(5'h10, 32'h0);
    slv_word = slv; slv_idx = w - 1; miso = slv[w-1];
    cap = '0; pulses = 0; mosi_bad = 0; mosi_at_rise = mosi;
    bus_write(5'h08, txv);
    while (cnt < 2000) begin
      @(negedge clk);
      bus_wr = 1'b0;
      cnt++;
      if (irq) break;
      if (cnt == mid_at) begin
        bus_addr = 5'h08; bus_wdata = ~txv; bus_wr = 1'b1;
      end
    end
    check({tag, " R9 cycles"}, cnt, w * n_exp);
    check({tag, " R4 period"}, 32'(t_rise1 - t_rise0), 32'(n_exp * 20));
    check({tag, w16 ? " R8 pulses" : " R7 pulses"}, pulses, w);
    check({tag, w16 ? " R8 mosi" : " R7 mosi"}, w16 ? cap : {8'h00, cap[7:0]}, exp_tx);
    check({tag, " R6 mosi stable"}, mosi_bad, 0);
    check({tag, " R6 sclk idle"}, sclk, 0);
    bus_read(5'h0C, rd);
    check({tag, w16 ? " R8 rx" : " R7 rx"}, rd, exp_rx);
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    check("R1 sel_n", sel_n, 1);
    check("R1 sclk", sclk, 0);
    check("R1 irq", irq, 0);
    bus_read(5'h00, rd); check("R1 ctrl", rd, 0);
    bus_read(5'h04, rd); check("R1 cfg", rd, 0);
    bus_read(5'h0C, rd); check("R1 rx", rd, 0);
    bus_read(5'h10, rd); check("R1 cause", rd, 0);
  endtask

  task automatic t_select;
    logic [31:0] rd;
    bus_write(5'h00, 32'h1);
    check("R2 sel low", sel_n, 0);
    bus_read(5'h00, rd); check("R2 readback", rd, 1);
    bus_write(5'h00, 32'h0);
    check("R2 sel high", sel_n, 1);
  endtask

  task automatic t_config;
    logic [31:0] rd;
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_read(5'h04, rd); check("R3 cfg all ones", rd, 32'h0000_403F);
    bus_write(5'h04, 32'h0000_4012);
    bus_read(5'h04, rd); check("R3 cfg pattern", rd, 32'h0000_4012);
  endtask

  task automatic t_cause;
    logic [31:0] rd;
    bus_read(5'h10, rd); check("R9 cause set", rd, 1);
    bus_write(5'h10, 32'h0);
    check("R9 irq cleared", irq, 0);
    bus_write(5'h10, 32'h1);
    bus_read(5'h10, rd); check("R9 write one no set", rd, 0);
    check("R9 irq stays low", irq, 0);
  endtask

  initial begin : watchdog
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    slv_word = '0; slv_idx = 0; cap = '0; pulses = 0; mosi_bad = 0;
    t_rise0 = 0; t_rise1 = 0; mosi_at_rise = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_config();
    run_word("w8 n4", 5'h12, 1'b0, 32'h0000_00A5, 16'h003C, 4, 0);
    t_cause();
    run_word("w16 n30", 5'h1F, 1'b1, 32'h0000_BEEF, 16'h1234, 30, 0);
    run_word("R5 bit4 clear", 5'h07, 1'b0, 32'h0000_00C3, 16'h0096, 4, 0);
    run_word("R5 k one", 5'h11, 1'b0, 32'h0000_0011, 16'h00F0, 4, 0);
    run_word("R7 upper ignored", 5'h15, 1'b0, 32'hFFFF_FF5A, 16'hAB69, 10, 0);
    run_word("R10 busy write", 5'h13, 1'b0, 32'h0000_0081, 16'h0042, 6, 5);
    run_word("w16 n8", 5'h14, 1'b1, 32'h0000_8001, 16'hF00D, 8, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule